// File: doc/BRIEF.md
# Charge Status Blink Encoder

This block turns the state of a single-cell battery charger into one blink pattern on an active-low, open-drain indicator pin. The block does not drive the pad. It produces a single registered `pull_low` signal, and the pad cell uses it as its output enable. When `pull_low` is 1 the pin is pulled to ground and the lamp is on. When it is 0 the pin floats and the external pull-up holds it high.

Seven status events can be raised at the same time. Each one owns its own blink frequency. The encoder always shows the active event with the fastest blink. When that event clears, the next fastest one still present takes over. Each frequency comes from a numerically controlled phase accumulator clocked by a fixed reference clock. The accumulator step is derived at elaboration time from the reference frequency, so the rates stay correct when the reference changes. Two conditions override blinking:
- When the supply input is not valid, the pin is released.
- When the supply is valid but charging is disabled, the pin is held low.

The end-of-charge event is latched. Once seen, it keeps blinking until the supply input goes away.

Top module: `chg_status_blink`

## Requirements
- R1: While `in_valid` is 0, `pull_low` is 0 (pin released), whatever the other inputs are.
- R2: While `in_valid` is 1 and `chg_en` is 0, `pull_low` stays at 1 constantly.
- R3: Each event has a fixed blink frequency, and the bit position in `status_evt` fixes which event it is:
  - bit 0: end of charge, 4.1 Hz
  - bit 1: charging, 6.2 Hz
  - bit 2: overcharge, 8.2 Hz
  - bit 3: timeout, 10.2 Hz
  - bit 4: battery fell below the pre-charge level after fast charge, 12.8 Hz
  - bit 5: thermal warning, 14.2 Hz
  - bit 6: battery temperature fault, 16.2 Hz
  
  The shown event produces a square wave on `pull_low` with a period within 1% (or 2 reference cycles, whichever is larger) of `REF_HZ`/frequency.
- R4: When several bits of `status_evt` are set, the highest set bit (fastest frequency) is the one shown.
- R5: When the shown event clears while a lower event is still set, the lower event's frequency is shown.
- R6: A single-cycle pulse on bit 0 keeps end-of-charge blinking until `in_valid` drops. After `in_valid` returns, the latched end-of-charge is gone.
- R7: When the shown event changes, the phase restarts. `pull_low` goes to 1 within 2 cycles and stays at 1 for half of the new period (same tolerance as R3), so no runt pulse appears.
- R8: With `in_valid` = 1, `chg_en` = 1 and no event set (and none latched), `pull_low` is 0.
- R9: After reset, `pull_low` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed reference clock of `REF_HZ` hertz |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Supply input within its valid window |
| chg_en | input | 1 | Charger enable level; 0 forces the pin low |
| status_evt | input | 7 | Event flags, bit positions as in R3 |
| pull_low | output | 1 | Registered enable of the open-drain pull-down |

## Verification
A wrong priority choice or a lost end-of-charge latch does not show up as a stuck pin. It shows up as a blink period belonging to another event, and that difference is visible within one or two periods, which is at most about 500 reference cycles at the bench rate. A phase accumulator that is not restarted shows up in the first high interval after a change of event. That interval comes out shorter than half a period, so the check measures it directly after each switch. The override paths (invalid input, charging disabled, idle) leave `pull_low` constant, and they are checked over windows longer than the slowest half period.

// File: rtl/chg_blink_pkg.sv
package chg_blink_pkg;

  localparam int NUM_EVT = 7;
  localparam int IDX_W   = $clog2(NUM_EVT);

  // event bit positions; a higher position blinks faster and wins
  localparam int EV_EOC    = 0;
  localparam int EV_CHG    = 1;
  localparam int EV_OVCHG  = 2;
  localparam int EV_TMO    = 3;
  localparam int EV_LOWPRE = 4;
  localparam int EV_THWARN = 5;
  localparam int EV_TEMP   = 6;

  // blink frequency in tenths of a hertz for an event position
  function automatic int rate_dhz(input int idx);
    case (idx)
      EV_EOC:    return 41;
      EV_CHG:    return 62;
      EV_OVCHG:  return 82;
      EV_TMO:    return 102;
      EV_LOWPRE: return 128;
      EV_THWARN: return 142;
      EV_TEMP:   return 162;
      default:   return 0;
    endcase
  endfunction

  // rounded accumulator step: rate/10 * 2^accw / ref_hz
  function automatic longint phase_inc(input int ref_hz, input int rate, input int accw);
    longint num;
    longint den;
    num = (longint'(rate) << accw) + longint'(ref_hz) * 5;
    den = longint'(ref_hz) * 10;
    return num / den;
  endfunction

endpackage

// File: rtl/chg_eoc_hold.sv
module chg_eoc_hold
  import chg_blink_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [NUM_EVT-1:0] evt_eff_o
);

  logic held_q;

  always_ff @(posedge clk) begin
    if (rst)              held_q <= 1'b0;
    else if (!in_valid_i) held_q <= 1'b0;
    else if (evt_i[EV_EOC]) held_q <= 1'b1;
  end

  always_comb begin
    evt_eff_o         = evt_i;
    evt_eff_o[EV_EOC] = evt_i[EV_EOC] | held_q;
  end

  // R6: losing the supply forgets the latched end-of-charge
  p_eoc_drop_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid_i) |-> !held_q);

endmodule

// File: rtl/chg_rate_arbiter.sv
module chg_rate_arbiter
  import chg_blink_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [IDX_W-1:0]   sel_o,
  output logic               act_o
);

  always_comb begin
    sel_o = '0;
    act_o = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (evt_i[i]) begin
        sel_o = IDX_W'(i);
        act_o = 1'b1;
      end
    end
  end

  // R4: the chosen event is set and nothing above it is set
  p_top_wins_r4: assert property (@(posedge clk) disable iff (rst)
    act_o |-> (evt_i[sel_o] && (((evt_i >> sel_o) >> 1) == '0)));

  p_idle_none_r8: assert property (@(posedge clk) disable iff (rst)
    !act_o |-> (evt_i == '0));

endmodule

// File: rtl/chg_blink_nco.sv
module chg_blink_nco
  import chg_blink_pkg::*;
#(
  parameter int REF_HZ = 32768,
  parameter int ACC_W  = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] sel_i,
  input  logic             act_i,
  output logic             act_o,
  output logic             wave_low_o
);

  logic [ACC_W-1:0] inc_tab [NUM_EVT];
  logic [ACC_W-1:0] acc_q;
  logic [IDX_W-1:0] sel_q;
  logic             act_q;
  logic             restart;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_inc
    assign inc_tab[g] = ACC_W'(phase_inc(REF_HZ, rate_dhz(g), ACC_W));
  end

  assign restart = (sel_i != sel_q) || (act_i != act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      act_q <= 1'b0;
      acc_q <= '0;
    end else if (restart) begin
      sel_q <= sel_i;
      act_q <= act_i;
      acc_q <= '0;
    end else if (act_q) begin
      acc_q <= acc_q + inc_tab[sel_q];
    end else begin
      acc_q <= '0;
    end
  end

  assign act_o      = act_q;
  assign wave_low_o = act_q & ~acc_q[ACC_W-1];

  // R7: a change of the shown event begins with the pulled-low half
  p_restart_low_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(act_i) && (($past(sel_i) != $past(sel_q)) || !$past(act_q)))
      |-> wave_low_o);

endmodule

// File: rtl/chg_status_blink.sv
module chg_status_blink
  import chg_blink_pkg::*;
#(
  parameter int REF_HZ = 32768,
  parameter int ACC_W  = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               chg_en,
  input  logic [NUM_EVT-1:0] status_evt,
  output logic               pull_low
);

  logic [NUM_EVT-1:0] evt_eff;
  logic [IDX_W-1:0]   sel;
  logic               act;
  logic               act_q;
  logic               wave_low;

  chg_eoc_hold u_hold (
    .clk        (clk),
    .rst        (rst),
    .in_valid_i (in_valid),
    .evt_i      (status_evt),
    .evt_eff_o  (evt_eff)
  );

  chg_rate_arbiter u_arb (
    .clk   (clk),
    .rst   (rst),
    .evt_i (evt_eff),
    .sel_o (sel),
    .act_o (act)
  );

  chg_blink_nco #(.REF_HZ(REF_HZ), .ACC_W(ACC_W)) u_nco (
    .clk        (clk),
    .rst        (rst),
    .sel_i      (sel),
    .act_i      (act),
    .act_o      (act_q),
    .wave_low_o (wave_low)
  );

  always_ff @(posedge clk) begin
    if (rst)            pull_low <= 1'b0;
    else if (!in_valid) pull_low <= 1'b0;
    else if (!chg_en)   pull_low <= 1'b1;
    else                pull_low <= act_q & wave_low;
  end

  p_invalid_release_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> !pull_low);

  p_disabled_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && !$past(chg_en)) |-> pull_low);

  p_idle_release_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(chg_en) && !$past(act_q)) |-> !pull_low);

endmodule

// File: tb/tb_chg_status_blink.sv
`timescale 1ns/1ps
module tb_chg_status_blink;

  localparam int REF = 2000;
  localparam int NV  = 8;
  localparam int RATE [7] = '{41, 62, 82, 102, 128, 142, 162};
  localparam logic [6:0] VEC_EVT [NV] = '{7'b0000001, 7'b0000010, 7'b0000100, 7'b0001000,
                                          7'b0010000, 7'b0100000, 7'b1000000, 7'b0101010};
  localparam int VEC_IDX [NV] = '{0, 1, 2, 3, 4, 5, 6, 5};

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic chg_en = 0;
  logic [6:0] status_evt = '0;
  logic pull_low;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  chg_status_blink #(.REF_HZ(REF), .ACC_W(24)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .chg_en(chg_en),
    .status_evt(status_evt), .pull_low(pull_low)
  );

  function automatic real exp_per(input int idx);
    return 10.0 * REF / RATE[idx];
  endfunction

  function automatic bit near(input real got, input real want);
    real tol;
    real d;
    tol = want * 0.01;
    if (tol < 2.0) tol = 2.0;
    d = got - want;
    if (d < 0) d = -d;
    return d <= tol;
  endfunction

  task automatic chk(input bit ok, input string req, input real got, input real want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0.1f expected %0.1f", req, got, want);
    end
  endtask

  // cycles from one rise of pull_low to the next; also the high time
  task automatic meas(output int per, output int hi);
    logic prev;
    int n;
    per = -1; hi = -1;
    prev = pull_low;
    @(negedge clk);
    n = 0;
    while (!(pull_low && !prev)) begin
      prev = pull_low; @(negedge clk); n++;
      if (n > 3000) return;
    end
    per = 0; hi = 0;
    prev = pull_low;
    do begin
      if (pull_low) hi++;
      prev = pull_low; @(negedge clk); per++;
      if (per > 3000) return;
    end while (!(pull_low && !prev));
  endtask

  // number of cycles pull_low keeps one level over a window (returns cycles equal to lvl)
  task automatic hold_count(input int win, input logic lvl, output int same);
    same = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pull_low === lvl) same++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per;
    int hi;
    int same;
    repeat (4) @(negedge clk);
    chk(pull_low === 1'b0, "R9 reset", real'(pull_low), 0.0);
    rst = 0;
    in_valid = 1; chg_en = 1;

    // vector table: R3 rates, R4 priority with several bits set
    for (int v = 0; v < NV; v++) begin
      status_evt = VEC_EVT[v];
      repeat (4) @(negedge clk);
      meas(per, hi);
      chk(near(real'(per), exp_per(VEC_IDX[v])),
          (v == NV - 1) ? "R4 priority period" : "R3 period", real'(per), exp_per(VEC_IDX[v]));
    end

    // R3 duty at the slowest rate
    status_evt = 7'b0000001;
    repeat (4) @(negedge clk);
    meas(per, hi);
    chk(near(real'(hi), exp_per(0) / 2.0), "R3 duty", real'(hi), exp_per(0) / 2.0);

    // R7: switch to charging; first high interval is a full half period
    status_evt = 7'b0000010;
    @(negedge clk); @(negedge clk);
    chk(pull_low === 1'b1, "R7 restart low", real'(pull_low), 1.0);
    hi = 0;
    while (pull_low === 1'b1 && hi < 3000) begin hi++; @(negedge clk); end
    chk(near(real'(hi), exp_per(1) / 2.0), "R7 first half", real'(hi), exp_per(1) / 2.0);

    // R5: temperature fault over charging, then the fault clears
    status_evt = 7'b1000010;
    repeat (4) @(negedge clk);
    meas(per, hi);
    chk(near(real'(per), exp_per(6)), "R5 high event", real'(per), exp_per(6));
    status_evt = 7'b0000010;
    repeat (4) @(negedge clk);
    meas(per, hi);
    chk(near(real'(per), exp_per(1)), "R5 lower resumes", real'(per), exp_per(1));

    // R2: charging disabled holds the pin low
    chg_en = 0;
    repeat (3) @(negedge clk);
    hold_count(600, 1'b1, same);
    chk(same == 600, "R2 disabled hold", real'(same), 600.0);
    chg_en = 1;

    // R1: invalid supply releases the pin with every event set
    status_evt = 7'b1111111;
    in_valid = 0;
    repeat (3) @(negedge clk);
    hold_count(600, 1'b0, same);
    chk(same == 600, "R1 invalid release", real'(same), 600.0);
    in_valid = 1;

    // R8: idle releases
    status_evt = '0;
    repeat (3) @(negedge clk);
    hold_count(600, 1'b0, same);
    chk(same == 600, "R8 idle release", real'(same), 600.0);

    // R6: one-cycle end-of-charge pulse keeps blinking
    status_evt = 7'b0000001;
    @(negedge clk);
    status_evt = '0;
    repeat (4) @(negedge clk);
    meas(per, hi);
    chk(near(real'(per), exp_per(0)), "R6 latched period", real'(per), exp_per(0));
    meas(per, hi);
    chk(near(real'(per), exp_per(0)), "R6 still latched", real'(per), exp_per(0));
    in_valid = 0;
    repeat (3) @(negedge clk);
    in_valid = 1;
    repeat (3) @(negedge clk);
    hold_count(600, 1'b0, same);
    chk(same == 600, "R6 cleared by supply loss", real'(same), 600.0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule